// File: doc/BRIEF.md
# PHY Receive Event Statistics Counters

This block keeps three statistics counters for the receive side of a 10/100 Ethernet physical layer. Each counter is fed by event signals that detection logic elsewhere produces. The first counter records link disconnect events. The second records false carrier events: the carrier rose but no start-of-stream delimiter followed. The third records received packets that had at least one receive error and no collision.

Each counter has its own synchronous clear, which the management logic raises after a read. The three counters handle a full value in different ways. The disconnect count wraps back to zero. The false-carrier count and the error-packet count stop at their top value.

The false-carrier path is a state machine with four states:
- `FC_IDLE`: no carrier.
- `FC_DECIDE`: carrier is up and the block is waiting for a delimiter, for at most `WIN_CYC` cycles.
- `FC_STREAM`: the delimiter was seen.
- `FC_FALSE`: the block has already counted this carrier and waits for it to drop.

Its transitions are:
- `FC_IDLE` goes to `FC_STREAM` when carrier and delimiter arrive together, and to `FC_DECIDE` on carrier alone.
- `FC_DECIDE` goes to `FC_STREAM` on the delimiter.
- `FC_DECIDE` goes to `FC_IDLE`, counting one event, when carrier drops.
- `FC_DECIDE` goes to `FC_FALSE`, counting one event, when the window expires.
- `FC_STREAM` and `FC_FALSE` return to `FC_IDLE` when carrier drops.

The packet path has two states:
- `RX_IDLE` goes to `RX_BUSY` when a packet starts.
- `RX_BUSY` returns to `RX_IDLE` when the packet ends. At that point it evaluates and clears the sticky error and collision flags.

Top module: `phy_rx_event_counters`

## Requirements
- R1: After reset all three counters read zero.
- R2: The disconnect counter rises by one for every clock cycle in which `disc_evt` is high.
- R3: The disconnect counter wraps from 0xFFFF to 0x0000.
- R4: A carrier assertion that ends before any delimiter and before the window expires adds one to the false-carrier counter. The count appears on the clock edge that samples `crs` low.
- R5: A carrier held high for more than `WIN_CYC` sampled cycles (default 8) after its rising cycle, with no delimiter, adds exactly one to the false-carrier counter, however long it lasts.
- R6: A carrier assertion in which `ssd_det` is high no later than `WIN_CYC` cycles after the rising cycle adds nothing.
- R7: The false-carrier counter holds at its all-ones value once full.
- R8: A packet is the run of cycles with `pkt_active` high. If `rx_err` was high in any cycle of the packet, the receive-error counter adds one, however many error cycles there were. The increment is made on the edge that samples `pkt_active` low, not earlier.
- R9: A packet with `col` high in any of its cycles adds nothing to the receive-error counter, even if it had errors.
- R10: `rx_err` outside a packet, and packets with no error, leave the receive-error counter unchanged.
- R11: The receive-error counter holds at its all-ones value once full.
- R12: Each clear input zeroes only its own counter on the next edge. A clear wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_evt | input | 1 | Disconnect event strobe, one count per high cycle |
| crs | input | 1 | Carrier sense level |
| ssd_det | input | 1 | Start-of-stream delimiter detected |
| pkt_active | input | 1 | High for each cycle of packet reception |
| rx_err | input | 1 | Receive error seen this cycle |
| col | input | 1 | Collision seen this cycle |
| clr_disc | input | 1 | Synchronous clear of the disconnect counter |
| clr_fcar | input | 1 | Synchronous clear of the false-carrier counter |
| clr_rxerr | input | 1 | Synchronous clear of the receive-error counter |
| disc_cnt | output | COUNT_W | Disconnect count |
| fcar_cnt | output | COUNT_W | False-carrier count |
| rxerr_cnt | output | COUNT_W | Receive-error packet count |

## Verification
The packet path is driven with a set of packets of different lengths:
- One early error and many errors tell a per-packet count apart from a per-cycle count.
- An error in the last cycle and a single-cycle packet show that the last active cycle is still sampled.
- A collision placed before the error and a collision placed after it show that the collision flag is sticky.

The carrier path is driven with:
- short bursts;
- long bursts with no delimiter;
- a delimiter in the same cycle as the rising carrier;
- a delimiter early in the window;
- a delimiter after the window.

Together these separate counting at the drop, counting at window expiry and suppression by the delimiter. A narrow instance reaches the full value quickly, so saturation can be told apart from wrapping.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
    typedef enum logic [1:0] {
        FC_IDLE,
        FC_DECIDE,
        FC_STREAM,
        FC_FALSE
    } fc_state_t;

    typedef enum logic {
        RX_IDLE,
        RX_BUSY
    } rx_state_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int COUNT_W  = 16,
    parameter bit SATURATE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               clr,
    output logic [COUNT_W-1:0] cnt
);
    localparam logic [COUNT_W-1:0] MAXV = '1;

    logic [COUNT_W-1:0] nxt;

    generate
        if (SATURATE) begin : g_sat
            always_comb nxt = (cnt == MAXV) ? cnt : cnt + 1'b1;
        end else begin : g_wrap
            always_comb nxt = cnt + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= nxt;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R12

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != MAXV) |=> (cnt == $past(cnt) + {{(COUNT_W-1){1'b0}}, $past(inc)})); // R2

    generate
        if (SATURATE) begin : g_sat_chk
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && cnt == MAXV) |=> (cnt == MAXV)); // R7, R11
        end else begin : g_wrap_chk
            AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && inc && cnt == MAXV) |=> (cnt == '0)); // R3
        end
    endgenerate
endmodule

// File: rtl/false_carrier_fsm.sv
module false_carrier_fsm
    import phy_evt_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs,
    input  logic ssd_det,
    output logic fc_evt
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    fc_state_t        state, state_nxt;
    logic [WIN_W-1:0] win_cnt;
    logic             win_done;

    assign win_done = (win_cnt == WIN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= FC_IDLE;
            win_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state == FC_DECIDE) win_cnt <= win_cnt + 1'b1;
            else                    win_cnt <= '0;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FC_IDLE: begin
                if (crs && ssd_det) state_nxt = FC_STREAM;
                else if (crs)       state_nxt = FC_DECIDE;
            end
            FC_DECIDE: begin
                if (ssd_det)       state_nxt = FC_STREAM;
                else if (!crs)     state_nxt = FC_IDLE;
                else if (win_done) state_nxt = FC_FALSE;
            end
            FC_STREAM: if (!crs) state_nxt = FC_IDLE;
            FC_FALSE:  if (!crs) state_nxt = FC_IDLE;
            default:   state_nxt = FC_IDLE;
        endcase
    end

    always_comb begin
        fc_evt = 1'b0;
        unique case (state)
            FC_DECIDE: fc_evt = !ssd_det && (!crs || win_done);
            default:   fc_evt = 1'b0;
        endcase
    end

    AST_FC_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_STREAM) |-> !fc_evt); // R6

    AST_FC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fc_evt |=> (state != FC_DECIDE)); // R5
endmodule

// File: rtl/rx_err_tracker.sv
module rx_err_tracker
    import phy_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_active,
    input  logic rx_err,
    input  logic col,
    output logic err_evt
);
    rx_state_t state, state_nxt;
    logic      err_seen, col_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            err_seen <= 1'b0;
            col_seen <= 1'b0;
        end else begin
            state <= state_nxt;
            if (pkt_active) begin
                err_seen <= err_seen | rx_err;
                col_seen <= col_seen | col;
            end else begin
                err_seen <= 1'b0;
                col_seen <= 1'b0;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE: if (pkt_active)  state_nxt = RX_BUSY;
            RX_BUSY: if (!pkt_active) state_nxt = RX_IDLE;
            default: state_nxt = RX_IDLE;
        endcase
    end

    always_comb begin
        err_evt = 1'b0;
        unique case (state)
            RX_BUSY: err_evt = !pkt_active && err_seen && !col_seen;
            default: err_evt = 1'b0;
        endcase
    end

    AST_RX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> ($past(pkt_active) && !pkt_active)); // R8

    AST_RX_COL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY && col_seen) |-> !err_evt); // R9

    AST_RX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |-> !err_evt); // R10
endmodule

// File: rtl/phy_rx_event_counters.sv
module phy_rx_event_counters #(
    parameter int COUNT_W = 16,
    parameter int WIN_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disc_evt,
    input  logic               crs,
    input  logic               ssd_det,
    input  logic               pkt_active,
    input  logic               rx_err,
    input  logic               col,
    input  logic               clr_disc,
    input  logic               clr_fcar,
    input  logic               clr_rxerr,
    output logic [COUNT_W-1:0] disc_cnt,
    output logic [COUNT_W-1:0] fcar_cnt,
    output logic [COUNT_W-1:0] rxerr_cnt
);
    logic fc_evt;
    logic err_evt;

    false_carrier_fsm #(.WIN_CYC(WIN_CYC)) i_fc (
        .clk(clk), .rst_n(rst_n), .crs(crs), .ssd_det(ssd_det), .fc_evt(fc_evt)
    );

    rx_err_tracker i_rx (
        .clk(clk), .rst_n(rst_n), .pkt_active(pkt_active),
        .rx_err(rx_err), .col(col), .err_evt(err_evt)
    );

    evt_counter #(.COUNT_W(COUNT_W), .SATURATE(1'b0)) i_disc_cnt (
        .clk(clk), .rst_n(rst_n), .inc(disc_evt), .clr(clr_disc), .cnt(disc_cnt)
    );

    evt_counter #(.COUNT_W(COUNT_W), .SATURATE(1'b1)) i_fcar_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fc_evt), .clr(clr_fcar), .cnt(fcar_cnt)
    );

    evt_counter #(.COUNT_W(COUNT_W), .SATURATE(1'b1)) i_rxerr_cnt (
        .clk(clk), .rst_n(rst_n), .inc(err_evt), .clr(clr_rxerr), .cnt(rxerr_cnt)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        $rose(rst_n) |-> (disc_cnt == '0 && fcar_cnt == '0 && rxerr_cnt == '0)); // R1

    AST_PKT_NO_FC: assert property (@(posedge clk) disable iff (!rst_n)
        (!crs && !$past(crs) && !clr_fcar) |=> $stable(fcar_cnt)); // R4
endmodule

// File: tb/test_phy_rx_event_counters.sv
`timescale 1ns/1ps
module test_phy_rx_event_counters;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disc_evt = 0, crs = 0, ssd_det = 0, pkt_active = 0, rx_err = 0, col = 0;
    logic clr_disc = 0, clr_fcar = 0, clr_rxerr = 0;
    logic [15:0] disc_cnt, fcar_cnt, rxerr_cnt;
    logic [3:0]  n_disc, n_fcar, n_rxerr;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_fc, exp_rx;

    always #4 clk = ~clk;

    phy_rx_event_counters i_phy_rx_event_counters (
        .clk(clk), .rst_n(rst_n), .disc_evt(disc_evt), .crs(crs), .ssd_det(ssd_det),
        .pkt_active(pkt_active), .rx_err(rx_err), .col(col),
        .clr_disc(clr_disc), .clr_fcar(clr_fcar), .clr_rxerr(clr_rxerr),
        .disc_cnt(disc_cnt), .fcar_cnt(fcar_cnt), .rxerr_cnt(rxerr_cnt)
    );

    phy_rx_event_counters #(.COUNT_W(4)) i_phy_rx_event_counters_narrow (
        .clk(clk), .rst_n(rst_n), .disc_evt(disc_evt), .crs(crs), .ssd_det(ssd_det),
        .pkt_active(pkt_active), .rx_err(rx_err), .col(col),
        .clr_disc(clr_disc), .clr_fcar(clr_fcar), .clr_rxerr(clr_rxerr),
        .disc_cnt(n_disc), .fcar_cnt(n_fcar), .rxerr_cnt(n_rxerr)
    );

    // packet vectors: bit i of err/col applies to packet cycle i
    typedef struct packed {
        logic [3:0] len;
        logic [7:0] err;
        logic [7:0] col;
        logic       inc;
    } pkt_vec_t;

    localparam pkt_vec_t PKT_TAB [7] = '{
        '{4'd4, 8'h01, 8'h00, 1'b1},
        '{4'd6, 8'h3F, 8'h00, 1'b1},
        '{4'd5, 8'h00, 8'h00, 1'b0},
        '{4'd5, 8'h02, 8'h10, 1'b0},
        '{4'd3, 8'h04, 8'h01, 1'b0},
        '{4'd1, 8'h01, 8'h00, 1'b1},
        '{4'd8, 8'h80, 8'h00, 1'b1}
    };

    // carrier vectors: ssd_at = 31 means no delimiter
    typedef struct packed {
        logic [4:0] len;
        logic [4:0] ssd_at;
        logic       inc;
    } crs_vec_t;

    localparam crs_vec_t CRS_TAB [6] = '{
        '{5'd3,  5'd31, 1'b1},
        '{5'd20, 5'd31, 1'b1},
        '{5'd10, 5'd2,  1'b0},
        '{5'd10, 5'd0,  1'b0},
        '{5'd15, 5'd12, 1'b1},
        '{5'd1,  5'd31, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_pkt(input logic [3:0] len, input logic [7:0] e, input logic [7:0] c);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pkt_active = 1'b1; rx_err = e[i]; col = c[i];
        end
        @(negedge clk);
        pkt_active = 1'b0; rx_err = 1'b0; col = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_crs(input logic [4:0] len, input logic [4:0] ssd_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            crs = 1'b1; ssd_det = (i == ssd_at);
        end
        @(negedge clk);
        crs = 1'b0; ssd_det = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_disc = 1; clr_fcar = 1; clr_rxerr = 1;
        @(negedge clk);
        clr_disc = 0; clr_fcar = 0; clr_rxerr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 disc reset", disc_cnt, 16'h0);
        chk("R1 fcar reset", fcar_cnt, 16'h0);
        chk("R1 rxerr reset", rxerr_cnt, 16'h0);

        // R8 R9 R10: packet table
        exp_rx = 16'h0;
        foreach (PKT_TAB[k]) begin
            run_pkt(PKT_TAB[k].len, PKT_TAB[k].err, PKT_TAB[k].col);
            exp_rx = exp_rx + {15'h0, PKT_TAB[k].inc};
            chk($sformatf("R8 R9 R10 packet vector %0d", k), rxerr_cnt, exp_rx);
        end

        // R4 R5 R6: carrier table
        exp_fc = 16'h0;
        foreach (CRS_TAB[k]) begin
            run_crs(CRS_TAB[k].len, CRS_TAB[k].ssd_at);
            exp_fc = exp_fc + {15'h0, CRS_TAB[k].inc};
            chk($sformatf("R4 R5 R6 carrier vector %0d", k), fcar_cnt, exp_fc);
        end

        // R8: no increment before the packet ends
        @(negedge clk); pkt_active = 1; rx_err = 1;
        @(negedge clk); rx_err = 0;
        @(negedge clk);
        chk("R8 mid-packet unchanged", rxerr_cnt, exp_rx);
        pkt_active = 0;
        @(negedge clk);
        exp_rx = exp_rx + 16'h1;
        chk("R8 counted at end", rxerr_cnt, exp_rx);

        // R10: error outside a packet ignored
        @(negedge clk); rx_err = 1;
        repeat (3) @(negedge clk);
        rx_err = 0;
        @(negedge clk);
        chk("R10 stray error ignored", rxerr_cnt, exp_rx);

        // R2: disconnect strobes
        @(negedge clk); disc_evt = 1;
        repeat (5) @(negedge clk);
        disc_evt = 0;
        @(negedge clk);
        chk("R2 five disconnects", disc_cnt, 16'd5);

        // R12: clear beats increment, others untouched
        disc_evt = 1; clr_disc = 1;
        @(negedge clk);
        disc_evt = 0; clr_disc = 0;
        chk("R12 disc cleared", disc_cnt, 16'h0);
        chk("R12 fcar untouched", fcar_cnt, exp_fc);
        chk("R12 rxerr untouched", rxerr_cnt, exp_rx);
        pkt_active = 1; rx_err = 1;
        @(negedge clk);
        pkt_active = 0; rx_err = 0; clr_rxerr = 1;
        @(negedge clk);
        clr_rxerr = 0;
        chk("R12 rxerr clear at packet end", rxerr_cnt, 16'h0);
        clr_fcar = 1;
        @(negedge clk);
        clr_fcar = 0;
        chk("R12 fcar cleared", fcar_cnt, 16'h0);
        chk("R12 disc still zero", disc_cnt, 16'h0);

        // R3: disconnect wrap at 16 bits
        disc_evt = 1;
        repeat (65535) @(negedge clk);
        chk("R3 disc at full", disc_cnt, 16'hFFFF);
        @(negedge clk);
        disc_evt = 0;
        chk("R3 disc wrapped", disc_cnt, 16'h0);

        // R7 R11: saturation on the narrow instance
        clear_all();
        for (int i = 0; i < 20; i++) run_crs(5'd2, 5'd31);
        chk("R7 narrow fcar saturates", {12'h0, n_fcar}, 16'h000F);
        chk("R7 wide fcar keeps counting", fcar_cnt, 16'd20);
        for (int i = 0; i < 20; i++) run_pkt(4'd2, 8'h01, 8'h00);
        chk("R11 narrow rxerr saturates", {12'h0, n_rxerr}, 16'h000F);
        chk("R11 wide rxerr keeps counting", rxerr_cnt, 16'd20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule